// File: doc/BRIEF.md
# Interrupt Vector Receive Latch

This block sits between an interrupt fabric and a processor core. The fabric drives a bank of numbered vector request lines, each one a level. The block watches every line for a rising edge. When it is idle it captures one incoming vector. It raises a busy flag, builds three data words that describe the vector, loads a fixed trap index that marks the vector trap as the highest-priority trap, and asserts a hard-interrupt request towards the core. On the cycle of capture it also gives a one-cycle wake pulse, which releases a halted core.

While the block is busy, further raises are dropped. The captured vector is released only when one of the request lines falls. That falling edge clears the busy flag and withdraws the hard-interrupt request. The data words and the trap index keep their last captured values. If several lines rise in the same idle cycle, the line with the lowest number is taken.

Top module: `ivec_rx_latch`

## Requirements
- R1: A rising edge on any request line while busy is low sets busy on the next clock edge.
- R2: On capture, trap_index becomes 0x60 and hard_req goes high on the same edge as busy.
- R3: On capture, vec_word0 holds 0x1f in bits 10:6 and the captured line number in bits 5:0, with all other bits zero. vec_word1 and vec_word2 are cleared to zero.
- R4: wake is high for exactly the one cycle that follows a capture edge and is low otherwise.
- R5: A rising edge while busy is high is ignored. Busy, the data words and the trap index keep their values.
- R6: A falling edge on any request line while busy clears busy and hard_req on the next edge, and leaves the data words and trap index unchanged. It takes precedence over a rise in the same cycle, and that rise is lost.
- R7: A falling edge while busy is low has no effect on any output.
- R8: When several lines rise in the same idle cycle, the lowest-numbered line is captured.
- R9: Reset clears busy, hard_req, wake, trap_index and all data words. The previous-level history also resets to zero, so a line that is already high when reset is released counts as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vec_lines | input | NUM_LINES | Level of each numbered vector request line |
| busy | output | 1 | A vector is held |
| hard_req | output | 1 | Hard-interrupt request to the core |
| trap_index | output | 9 | Trap index of the pending interrupt |
| vec_word0 | output | 64 | Data word 0: marker and line number |
| vec_word1 | output | 64 | Data word 1, zero after capture |
| vec_word2 | output | 64 | Data word 2, zero after capture |
| wake | output | 1 | One-cycle pulse that releases a halted core |

## Verification
The bench first raises a single mid-range line to check the word format. It then raises several lines together, among them the top number, to tell lowest-first arbitration apart from highest-first or last-index selection. A rise during busy separates a latch that drops raises from one that overwrites the held vector. A rise and a fall in the same cycle show that the fall wins. A fall while idle, and a line held high across reset release, probe the edge history: the first must do nothing and the second must count as a capture.

// File: rtl/ivr_pkg.sv
package ivr_pkg;
    localparam int WORD_W     = 64;
    localparam int TRAP_W     = 9;
    localparam logic [TRAP_W-1:0] VEC_TRAP = 9'h060;
    localparam logic [4:0]   MARKER   = 5'h1f;
    localparam int MARK_LSB   = 6;

    typedef struct packed {
        logic              busy;
        logic              hard;
        logic              wake;
        logic [TRAP_W-1:0] trap;
        logic [WORD_W-1:0] word0;
        logic [WORD_W-1:0] word1;
        logic [WORD_W-1:0] word2;
    } latch_state_t;
endpackage

// File: rtl/ivr_edge_bank.sv
module ivr_edge_bank #(
    parameter int NUM_LINES = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] lines,
    output logic [NUM_LINES-1:0] rise,
    output logic [NUM_LINES-1:0] fall
);
    logic [NUM_LINES-1:0] prev_d, prev_q;

    assign prev_d = lines;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q[g] <= 1'b0;
            else        prev_q[g] <= prev_d[g];
        end
        assign rise[g] = lines[g] & ~prev_q[g];
        assign fall[g] = ~lines[g] & prev_q[g];
    end
endmodule

// File: rtl/ivr_prio_pick.sv
module ivr_prio_pick #(
    parameter int NUM_LINES = 64,
    parameter int NUM_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic [NUM_LINES-1:0] req,
    output logic                 valid,
    output logic [NUM_W-1:0]     idx
);
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (req[i]) begin
                valid = 1'b1;
                idx   = NUM_W'(i);
            end
        end
    end

    // R8: no request below the chosen index
    logic [NUM_LINES-1:0] below_mask;
    assign below_mask = (NUM_LINES'(1) << idx) - NUM_LINES'(1);
    always_comb begin
        if (valid) begin
            p_lowest_wins_r8: assert ((req & below_mask) == '0);
        end
    end
endmodule

// File: rtl/ivr_latch_core.sv
module ivr_latch_core
    import ivr_pkg::*;
#(
    parameter int NUM_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              any_rise,
    input  logic              any_fall,
    input  logic [NUM_W-1:0]  pick_idx,
    output latch_state_t      st
);
    latch_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.wake = 1'b0;
        if (st_q.busy && any_fall) begin
            st_d.busy = 1'b0;
            st_d.hard = 1'b0;
        end else if (!st_q.busy && any_rise) begin
            st_d.busy  = 1'b1;
            st_d.hard  = 1'b1;
            st_d.wake  = 1'b1;
            st_d.trap  = VEC_TRAP;
            st_d.word0 = '0;
            st_d.word0[MARK_LSB +: 5] = MARKER;
            st_d.word0[NUM_W-1:0]     = pick_idx;
            st_d.word1 = '0;
            st_d.word2 = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign st = st_q;

    p_accept_sets_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.busy && any_rise) |=> st_q.busy);
    p_accept_trap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.busy && any_rise) |=> (st_q.trap == VEC_TRAP && st_q.hard));
    p_word_format_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> (st_q.word0[MARK_LSB +: 5] == MARKER
                       && st_q.word1 == '0 && st_q.word2 == '0));
    p_wake_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wake |=> !st_q.wake);
    p_ignore_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && any_rise && !any_fall) |=> ($stable(st_q.word0) && st_q.busy));
    p_fall_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && any_fall) |=> (!st_q.busy && !st_q.hard && $stable(st_q.word0)));
    p_idle_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.busy && !any_rise) |=> (!st_q.busy && $stable(st_q.word0)));
endmodule

// File: rtl/ivec_rx_latch.sv
module ivec_rx_latch
    import ivr_pkg::*;
#(
    parameter int NUM_LINES = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] vec_lines,
    output logic                 busy,
    output logic                 hard_req,
    output logic [TRAP_W-1:0]    trap_index,
    output logic [WORD_W-1:0]    vec_word0,
    output logic [WORD_W-1:0]    vec_word1,
    output logic [WORD_W-1:0]    vec_word2,
    output logic                 wake
);
    localparam int NUM_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

    logic [NUM_LINES-1:0] rise, fall;
    logic                 pick_valid;
    logic [NUM_W-1:0]     pick_idx;
    latch_state_t         st;

    ivr_edge_bank #(.NUM_LINES(NUM_LINES)) u_edges (
        .clk(clk), .rst_n(rst_n), .lines(vec_lines), .rise(rise), .fall(fall)
    );

    ivr_prio_pick #(.NUM_LINES(NUM_LINES), .NUM_W(NUM_W)) u_pick (
        .req(rise), .valid(pick_valid), .idx(pick_idx)
    );

    ivr_latch_core #(.NUM_W(NUM_W)) u_core (
        .clk(clk), .rst_n(rst_n), .any_rise(pick_valid), .any_fall(|fall),
        .pick_idx(pick_idx), .st(st)
    );

    assign busy       = st.busy;
    assign hard_req   = st.hard;
    assign trap_index = st.trap;
    assign vec_word0  = st.word0;
    assign vec_word1  = st.word1;
    assign vec_word2  = st.word2;
    assign wake       = st.wake;
endmodule

// File: tb/ivec_rx_latch_tb_top.sv
module ivec_rx_latch_tb_top;
    localparam int N = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] lines = '0;
    logic         busy, hard_req, wake;
    logic [8:0]   trap_index;
    logic [63:0]  w0, w1, w2;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ivec_rx_latch #(.NUM_LINES(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .vec_lines(lines), .busy(busy),
        .hard_req(hard_req), .trap_index(trap_index), .vec_word0(w0),
        .vec_word1(w1), .vec_word2(w2), .wake(wake)
    );

    // Behavioural reference model
    logic [N-1:0] m_prev = '0;
    bit           m_busy = 0, m_hard = 0, m_wake = 0;
    logic [8:0]   m_trap = '0;
    logic [63:0]  m_w0 = '0, m_w1 = '0, m_w2 = '0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_prev = '0; m_busy = 0; m_hard = 0; m_wake = 0;
            m_trap = '0; m_w0 = '0; m_w1 = '0; m_w2 = '0;
        end else begin
            bit any_up, any_down;
            int first;
            any_up = 0; any_down = 0; first = -1;
            for (int k = 0; k < N; k++) begin
                if (lines[k] && !m_prev[k]) begin
                    any_up = 1;
                    if (first < 0) first = k;
                end
                if (!lines[k] && m_prev[k]) any_down = 1;
            end
            m_wake = 0;
            if (m_busy && any_down) begin
                m_busy = 0; m_hard = 0;
            end else if (!m_busy && any_up) begin
                m_busy = 1; m_hard = 1; m_wake = 1; m_trap = 9'h060;
                m_w0 = 64'h7c0 + 64'(first); m_w1 = '0; m_w2 = '0;
            end
            m_prev = lines;
        end
    end

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R1 busy", 64'(busy), 64'(m_busy));
            chk("R2 hard_req", 64'(hard_req), 64'(m_hard));
            chk("R2 trap_index", 64'(trap_index), 64'(m_trap));
            chk("R3 word0", w0, m_w0);
            chk("R3 word1", w1, m_w1);
            chk("R3 word2", w2, m_w2);
            chk("R4 wake", 64'(wake), 64'(m_wake));
        end
    end

    task automatic drive(logic [N-1:0] v);
        @(negedge clk);
        lines = v;
        @(negedge clk);
        #0.5;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R9 reset busy", 64'(busy), 64'd0);
        chk("R9 reset word0", w0, 64'd0);
        chk("R9 reset trap", 64'(trap_index), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        drive(64'h20);                       // line 5
        chk("R1 capture busy", 64'(busy), 64'd1);
        chk("R3 word0 line5", w0, 64'h7c5);
        chk("R2 trap", 64'(trap_index), 64'h60);
        chk("R4 wake pulse", 64'(wake), 64'd1);
        @(negedge clk); #0.5;
        chk("R4 wake drops", 64'(wake), 64'd0);

        drive(64'h24);                       // raise line 2 while busy
        chk("R5 still busy", 64'(busy), 64'd1);
        chk("R5 word0 kept", w0, 64'h7c5);

        drive(64'h20);                       // drop line 2
        chk("R6 cleared", 64'(busy), 64'd0);
        chk("R6 req cleared", 64'(hard_req), 64'd0);
        chk("R6 word0 kept", w0, 64'h7c5);

        drive(64'h0);                        // drop line 5 while idle
        chk("R7 idle fall busy", 64'(busy), 64'd0);
        chk("R7 idle fall word0", w0, 64'h7c5);

        drive((64'd1 << 9) | (64'd1 << 40) | (64'd1 << 63));
        chk("R8 lowest wins", w0, 64'h7c9);

        drive((64'd1 << 40) | (64'd1 << 63)); // fall clears
        drive(64'h0);
        drive(64'd1 << 63);
        chk("R3 top number", w0, 64'h7ff);

        drive(64'd1);                         // fall 63 and rise 0 together
        chk("R6 fall beats rise", 64'(busy), 64'd0);
        chk("R6 rise lost word0", w0, 64'h7ff);
        repeat (3) @(negedge clk);
        chk("R6 lost rise stays lost", 64'(busy), 64'd0);

        @(negedge clk);
        rst_n = 1'b0;                         // line 0 still high
        #1;
        chk("R9 async reset busy", 64'(busy), 64'd0);
        chk("R9 async reset word0", w0, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #0.5;
        chk("R9 high line counts as rise", 64'(busy), 64'd1);
        chk("R9 word0 line0", w0, 64'h7c0);
        repeat (2) @(negedge clk);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule